// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory

This block is a model of a serial bitstream store that an FPGA reads during serial configuration. It holds a bit array of parameterised depth, filled one word at a time through a load port. A configuration clock steps an internal address counter, and the bit at the current address appears on a single data output. A separate drive-enable output takes the place of a three-state pin. The current bit is read straight from the counter, so a reader that samples on each rising edge receives the bits in address order, and every such edge moves the counter to the next bit.

Two inputs gate the block: an active-low chip enable and a combined reset/output-enable pin. A parameter sets the polarity of that pin. At its reset level the counter is cleared and the data output is released. When the last bit has been handed out, the block drives its chip-enable output low and stops driving data. The next memory in a chain has its chip enable tied to that output, so it takes over the shared data line on the very next bit.

Top module: `serial_cfg_mem`

## Requirements
- R1: While the reset/output-enable pin is at its reset level, `dout_en` is 0, `ce_out_n` is 1, and after the pin is released reading starts again at address 0.
- R2: `RST_POL` selects the reset level: `RST_HIGH` (default) treats `roe`=1 as reset, and `RST_LOW` treats `roe`=0 as reset.
- R3: On each rising `clk` edge where `ce_n`=0, the pin is not at its reset level and the end has not been reached, the counter advances by exactly one, so one bit is handed out per edge.
- R4: While `ce_n`=1 the counter and the end flag hold their values and `dout_en` is 0.
- R5: `dout_en` is 1 only while `ce_n`=0, the pin is not at reset and the last bit has not yet been consumed. `dout_en` and a low `ce_out_n` never occur together.
- R6: On the edge that consumes the bit at address DEPTH-1, the block goes to its end state. From the next cycle `dout_en` is 0 and `ce_out_n` is low while enabled. The end state lasts until reset.
- R7: In the end state `ce_out_n` equals `ce_n`.
- R8: With no reset in between, a pause (`ce_n`=1) followed by re-enable resumes at the address where reading stopped.
- R9: With `ld_we`=1, a rising edge writes `ld_data` to word `ld_addr`. Bit b of word w holds address w*WORD_W+b, so the least significant bit is read first.
- R10: Two instances chained through `ce_out_n`→`ce_n` on a shared line deliver the two arrays back to back, with no bit lost or repeated and at most one driver at a time.
- R11: A reset after the end state clears it: `ce_out_n` returns high and the next read starts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; the counter and the load port act on its rising edge |
| roe | input | 1 | Combined reset/output enable; polarity set by `RST_POL` |
| ce_n | input | 1 | Chip enable, active low |
| ld_we | input | 1 | Load write enable |
| ld_addr | input | log2(DEPTH/WORD_W) | Word address for loading |
| ld_data | input | WORD_W | Word to store |
| dout | output | 1 | Current bit, 0 when not driven |
| dout_en | output | 1 | Data-line drive enable |
| ce_out_n | output | 1 | Chain enable for the next memory, active low |

## Verification
The assertions assume that `roe` and `ce_n` change only between clock edges and that the load port is not used while a read is in progress. They also assume the block starts with its pin at the reset level, so the counter and end flag are cleared before any property is checked. The bench changes every input two nanoseconds after a rising edge and loads both arrays while holding the chain in reset. It applies reset again before the last part of the run, so the checker never sees a counter that was not cleared.

// File: rtl/scm_pkg.sv
// Package: shared types for the serial configuration memory.
// Assumes nothing; holds only the reset-polarity selector.
package scm_pkg;

    // Which level of the combined pin means reset.
    typedef enum logic {
        RST_HIGH = 1'b0,
        RST_LOW  = 1'b1
    } rst_pol_e;

endpackage

// File: rtl/scm_pin_decode.sv
// Module: scm_pin_decode
// Turns the combined reset/output-enable pin into an output-enable level.
// Assumes the pin is stable around the clock edge; the polarity is fixed at build time.
module scm_pin_decode #(
    parameter scm_pkg::rst_pol_e RST_POL = scm_pkg::RST_HIGH
) (
    input  logic roe,
    output logic oe_act
);

    generate
        if (RST_POL == scm_pkg::RST_HIGH) begin : g_rst_high
            // Pin high means reset, so output enable is its inverse.
            assign oe_act = ~roe;
        end else begin : g_rst_low
            // Pin low means reset, so output enable follows the pin.
            assign oe_act = roe;
        end
    endgenerate

endmodule

// File: rtl/scm_addr_ctr.sv
// Module: scm_addr_ctr
// Bit address counter with a sticky end-of-array flag.
// Assumes oe_act low acts as a synchronous reset; DEPTH is a power of two.
module scm_addr_ctr #(
    parameter int unsigned DEPTH = 4096,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          oe_act,
    input  logic          ce_act,
    output logic [AW-1:0] addr,
    output logic          done
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Clear on reset level, step while enabled, latch end flag on the last bit.
    always_ff @(posedge clk) begin
        if (!oe_act) begin
            addr <= '0;
            done <= 1'b0;
        end else if (ce_act && !done) begin
            if (addr == LAST) begin
                done <= 1'b1;
            end else begin
                addr <= addr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/scm_bit_store.sv
// Module: scm_bit_store
// Word-organised bit array with a word write port and a single-bit read.
// Assumes DEPTH is a multiple of WORD_W and both are powers of two.
module scm_bit_store #(
    parameter int unsigned DEPTH  = 4096,
    parameter int unsigned WORD_W = 16,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned WB     = $clog2(WORD_W),
    localparam int unsigned NWORDS = DEPTH / WORD_W,
    localparam int unsigned WA     = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              ld_we,
    input  logic [WA-1:0]     ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_bit
);

    logic [WORD_W-1:0] mem [NWORDS];
    logic [WORD_W-1:0] rd_word;

    // Store one word per write strobe.
    always_ff @(posedge clk) begin
        if (ld_we) begin
            mem[ld_addr] <= ld_data;
        end
    end

    // Select the word, then the bit, of the current address.
    always_comb begin
        rd_word = mem[rd_addr[AW-1:WB]];
        rd_bit  = rd_word[rd_addr[WB-1:0]];
    end

endmodule

// File: rtl/serial_cfg_mem.sv
// Module: serial_cfg_mem
// Serial configuration memory: one bit per clock, chainable through ce_out_n.
// Assumes roe and ce_n change away from the rising edge; loading happens
// while no read is in progress.
module serial_cfg_mem #(
    parameter int unsigned DEPTH  = 4096,
    parameter int unsigned WORD_W = 16,
    parameter scm_pkg::rst_pol_e RST_POL = scm_pkg::RST_HIGH,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned WA     = $clog2(DEPTH / WORD_W)
) (
    input  logic              clk,
    input  logic              roe,
    input  logic              ce_n,
    input  logic              ld_we,
    input  logic [WA-1:0]     ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    output logic              dout,
    output logic              dout_en,
    output logic              ce_out_n
);

    logic          oe_act;
    logic          enabled;
    logic [AW-1:0] cur_addr;
    logic          read_done;
    logic          cur_bit;

    scm_pin_decode #(.RST_POL(RST_POL)) u_pin_decode (
        .roe    (roe),
        .oe_act (oe_act)
    );

    scm_addr_ctr #(.DEPTH(DEPTH)) u_addr_ctr (
        .clk    (clk),
        .oe_act (oe_act),
        .ce_act (~ce_n),
        .addr   (cur_addr),
        .done   (read_done)
    );

    scm_bit_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_bit_store (
        .clk     (clk),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .rd_addr (cur_addr),
        .rd_bit  (cur_bit)
    );

    // Drive the line only while selected and bits remain; signal the chain afterwards.
    always_comb begin
        enabled  = ~ce_n & oe_act;
        dout_en  = enabled & ~read_done;
        dout     = dout_en & cur_bit;
        ce_out_n = ~(enabled & read_done);
    end

endmodule

// File: rtl/scm_checker.sv
// Module: scm_checker
// Temporal properties of serial_cfg_mem, attached through bind.
// Assumes the reset level is applied before the first read.
module scm_checker #(
    parameter int unsigned DEPTH = 4096,
    parameter scm_pkg::rst_pol_e RST_POL = scm_pkg::RST_HIGH,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          roe,
    input logic          ce_n,
    input logic          dout_en,
    input logic          ce_out_n,
    input logic [AW-1:0] addr,
    input logic          done
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic rst_lvl;
    assign rst_lvl = (RST_POL == scm_pkg::RST_HIGH) ? roe : ~roe;

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst_lvl |-> (!dout_en && ce_out_n));

    a_r1_reset_clears: assert property (@(posedge clk)
        rst_lvl |=> (addr == '0 && !done));

    a_r3_step_one: assert property (@(posedge clk) disable iff (rst_lvl)
        (!ce_n && !done && addr != LAST) |=> (addr == AW'($past(addr) + 1'b1)));

    a_r4_standby_undriven: assert property (@(posedge clk) disable iff (rst_lvl)
        ce_n |-> !dout_en);

    a_r4_standby_frozen: assert property (@(posedge clk) disable iff (rst_lvl)
        ce_n |=> ($stable(addr) && $stable(done)));

    a_r5_single_driver: assert property (@(posedge clk) disable iff (rst_lvl)
        !(dout_en && !ce_out_n));

    a_r6_end_entry: assert property (@(posedge clk) disable iff (rst_lvl)
        (!ce_n && !done && addr == LAST) |=> done);

    a_r6_end_sticky: assert property (@(posedge clk) disable iff (rst_lvl)
        done |=> done);

    a_r7_follow_ce: assert property (@(posedge clk) disable iff (rst_lvl)
        done |-> (ce_out_n == ce_n));

endmodule

bind serial_cfg_mem scm_checker #(.DEPTH(DEPTH), .RST_POL(RST_POL)) u_scm_checker (
    .clk      (clk),
    .roe      (roe),
    .ce_n     (ce_n),
    .dout_en  (dout_en),
    .ce_out_n (ce_out_n),
    .addr     (cur_addr),
    .done     (read_done)
);

// File: tb/serial_cfg_mem_bench.sv
// Bench: two chained memories on one shared data line, scoreboard checked.
module serial_cfg_mem_bench;

    localparam int unsigned DEPTH  = 32;
    localparam int unsigned WORD_W = 8;
    localparam int unsigned NW     = DEPTH / WORD_W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             roe;
    logic             head_ce_n;
    logic             ld_we;
    logic [1:0]       ld_addr;
    logic [WORD_W-1:0] ld_data0, ld_data1;
    logic             d0, d1, den0, den1, ceo0, ceo1;

    int checks = 0;
    int errors = 0;
    bit q_exp[$];

    // Head: active-high reset pin.
    serial_cfg_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W), .RST_POL(scm_pkg::RST_HIGH)) u_serial_cfg_mem (
        .clk(clk), .roe(roe), .ce_n(head_ce_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data0), .dout(d0), .dout_en(den0), .ce_out_n(ceo0)
    );

    // Tail: active-low reset pin, driven with the inverted signal (R2).
    serial_cfg_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W), .RST_POL(scm_pkg::RST_LOW)) u_tail (
        .clk(clk), .roe(~roe), .ce_n(ceo0), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data1), .dout(d1), .dout_en(den1), .ce_out_n(ceo1)
    );

    function automatic bit pat(int dev, int a);
        return bit'((a ^ (a >> 2) ^ (a >> 3) ^ dev) & 1);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_bits(int dev, int first, int count);
        for (int a = first; a < first + count; a++) q_exp.push_back(pat(dev, a));
    endtask

    // Monitor: every driven bit on the shared line is consumed at the next edge.
    always @(negedge clk) begin
        if (den0 && den1) begin
            check(1'b0, "R10 two drivers", 2, 1);
        end else if (den0 || den1) begin
            if (q_exp.size() == 0) begin
                check(1'b0, "R10 extra bit", 1, 0);
            end else begin
                bit exp_b;
                bit got_b;
                exp_b = q_exp.pop_front();
                got_b = den0 ? d0 : d1;
                check(got_b == exp_b, "R3 R9 R10 stream bit", got_b, exp_b);
            end
        end
    end

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        check(1'b0, "watchdog", 1, 0);
        finish_run();
    end

    initial begin
        roe = 1'b1; head_ce_n = 1'b0; ld_we = 1'b0; ld_addr = '0;
        ld_data0 = '0; ld_data1 = '0;
        repeat (2) @(posedge clk);
        #2;
        // R9: load both arrays, bit b of word w is address w*WORD_W+b.
        for (int w = 0; w < NW; w++) begin
            for (int b = 0; b < WORD_W; b++) begin
                ld_data0[b] = pat(0, w * WORD_W + b);
                ld_data1[b] = pat(1, w * WORD_W + b);
            end
            ld_addr = 2'(w);
            ld_we   = 1'b1;
            @(posedge clk);
            #2;
        end
        ld_we = 1'b0;
        @(negedge clk);
        check(!den0, "R1 head undriven in reset", den0, 0);
        check(ceo0,  "R1 head ce_out_n high in reset", ceo0, 1);
        check(!den1, "R2 tail undriven with low reset pin", den1, 0);
        check(ceo1,  "R2 tail ce_out_n high in reset", ceo1, 1);

        push_bits(0, 0, DEPTH);
        push_bits(1, 0, DEPTH);
        @(posedge clk); #2;
        roe = 1'b0;
        repeat (16) @(posedge clk);
        #2 head_ce_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(!den0 && !den1, "R4 undriven in standby", den0 | den1, 0);
        check(ceo0, "R4 head ce_out_n high in standby", ceo0, 1);
        check(q_exp.size() == 2 * DEPTH - 16, "R8 pause point", q_exp.size(), 2 * DEPTH - 16);

        @(posedge clk); #2 head_ce_n = 1'b0;
        repeat (60) @(posedge clk);
        @(negedge clk);
        check(q_exp.size() == 0, "R10 all bits delivered", q_exp.size(), 0);
        check(!den0 && !den1, "R6 line released at end", den0 | den1, 0);
        check(!ceo0, "R6 head ce_out_n low at end", ceo0, 0);
        check(!ceo1, "R6 tail ce_out_n low at end", ceo1, 0);

        @(posedge clk); #2 head_ce_n = 1'b1;
        @(negedge clk);
        check(ceo0, "R7 head ce_out_n follows ce_n high", ceo0, 1);
        check(ceo1, "R7 tail ce_out_n follows chain", ceo1, 1);
        @(posedge clk); #2 head_ce_n = 1'b0;
        @(negedge clk);
        check(!ceo0, "R7 head ce_out_n follows ce_n low", ceo0, 0);
        check(!den0, "R6 end state sticky", den0, 0);

        // R11: reset after the end restarts at address 0.
        @(posedge clk); #2 roe = 1'b1;
        repeat (2) @(posedge clk);
        push_bits(0, 0, 4);
        #2 roe = 1'b0;
        @(negedge clk);
        check(ceo0, "R11 ce_out_n high after reset", ceo0, 1);
        repeat (4) @(posedge clk);
        #2 head_ce_n = 1'b1;
        @(negedge clk);
        check(q_exp.size() == 0, "R11 restart from address 0", q_exp.size(), 0);
        finish_run();
    end

endmodule